// File: doc/BRIEF.md
# Latency-Hiding Thread Issue Scheduler

This block chooses which hardware thread context feeds an in-order, single-issue compute pipeline each cycle. Every context is in one of three states: idle, ready, or waiting on memory. Each cycle the scheduler offers at most one ready thread to the pipeline. The search is round-robin and starts just after the thread that issued most recently. Decode reports whether the offered instruction is a load. A load parks its thread in the waiting state at the end of that cycle, so the next cycle already issues from another thread and no cycle is spent on switching.

A thread can issue again only after the memory system returns a response tagged with its ID. There is no cache, so latency is hidden only by having enough other threads ready. If a response names a thread that is not waiting, the block flags it and ignores it. If no thread is ready, the block issues a bubble.

With a fixed memory latency of L cycles and round-robin selection, every issue slot is filled once at least L+1 threads run load-only code. With fewer active threads A, each window of L+1 cycles holds exactly A issues.

Top module: `thread_issue_sched`

## Requirements
- R1: After a synchronous reset, every thread is idle, `ready_mask` is all zero and `issue_valid` is 0.
- R2: A bit set in `launch_mask` makes the matching thread ready on the next cycle only if that thread is idle. For a thread that is waiting on memory, the launch bit has no effect.
- R3: At most one thread issues per cycle, and the issued thread is ready. When no thread is ready, `issue_valid` is 0 (a bubble).
- R4: The issued thread is the first ready thread found when searching upward, with wrap-around, from the thread ID after the last one issued. After reset, the search starts at thread 0.
- R5: A thread that issues a non-load instruction (`issue_is_load`=0) stays ready and can issue again in the next cycle.
- R6: A thread that issues with `issue_is_load`=1 is not ready from the next cycle on. It does not issue again until a response names it.
- R7: A response (`resp_valid`=1, `resp_tid`) for a waiting thread makes it ready on the next cycle. With latency L, a load issued in cycle c can issue again in cycle c+L+1.
- R8: A response for a thread that is not waiting drives `proto_err`=1 in the same cycle and leaves all thread states unchanged. `proto_err` is 0 when `resp_valid` is 0.
- R9: With L=100 and 128 threads all running loads, every cycle after launch issues, and in cycle r after launch the issued thread is r mod 128.
- R10: With L=100 and only threads 0..39 active running loads, cycle r after launch issues exactly when (r mod 101) < 40, and the issued thread is r mod 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_mask | input | NUM_THREADS | Per-thread request to move an idle thread to ready |
| issue_is_load | input | 1 | Decode says the offered instruction is a load |
| resp_valid | input | 1 | A memory response arrives this cycle |
| resp_tid | input | TID_W | Thread ID of the memory response |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | TID_W | ID of the issuing thread |
| ready_mask | output | NUM_THREADS | One bit per thread, set while the thread is ready |
| proto_err | output | 1 | Response names a thread that is not waiting |

## Verification
The properties assume the following:
- `issue_is_load` is a same-cycle function of the offered thread.
- At most one memory response arrives per cycle.
- `launch_mask` is used only as a one-cycle pulse.

The stimulus keeps within these assumptions in three ways:
- It derives `issue_is_load` from a fixed per-thread program indexed by `issue_tid`.
- It schedules each response exactly L cycles after its load. Because at most one load issues per cycle, responses never collide.
- It drives stray responses by hand only in cycles where no scheduled response is due.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

    typedef enum logic [1:0] {
        TH_IDLE  = 2'd0,
        TH_READY = 2'd1,
        TH_WAIT  = 2'd2
    } thr_state_e;

    // Next state of one context; each state reacts to one event only.
    function automatic thr_state_e thr_next(thr_state_e cur, logic launch,
                                            logic issued_load, logic resp);
        thr_state_e nxt;
        case (cur)
            TH_IDLE:  nxt = launch      ? TH_READY : TH_IDLE;
            TH_READY: nxt = issued_load ? TH_WAIT  : TH_READY;
            TH_WAIT:  nxt = resp        ? TH_READY : TH_WAIT;
            default:  nxt = TH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/thread_ctx.sv
module thread_ctx
    import thread_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic issue_me,
    input  logic is_load,
    input  logic resp_me,
    output logic ready,
    output logic waiting
);
    thr_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= TH_IDLE;
        else     state_q <= thr_next(state_q, launch, issue_me && is_load, resp_me);
    end

    assign ready   = (state_q == TH_READY);
    assign waiting = (state_q == TH_WAIT);

    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (launch && !ready && !waiting) |=> ready); // R2
    AST_LOAD_PARKS: assert property (@(posedge clk) disable iff (rst)
        (issue_me && is_load) |=> waiting); // R6
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (waiting && !resp_me) |=> waiting); // R6
    AST_RESP_WAKES: assert property (@(posedge clk) disable iff (rst)
        (waiting && resp_me) |=> ready); // R7
    AST_ALU_STAYS: assert property (@(posedge clk) disable iff (rst)
        (issue_me && !is_load) |=> ready); // R5
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N    = 16,
    parameter int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req,
    input  logic [ID_W-1:0] last_id,
    output logic            gnt_valid,
    output logic [ID_W-1:0] gnt_id
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_id    = '0;
        for (int k = 1; k <= N; k++) begin
            if (!gnt_valid && req[(int'(last_id) + k) % N]) begin
                gnt_valid = 1'b1;
                gnt_id    = ID_W'((int'(last_id) + k) % N);
            end
        end
    end

    AST_GRANT_IS_REQ: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> req[gnt_id]); // R3
    AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !gnt_valid |-> (req == '0)); // R3
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
    import thread_sched_pkg::*;
#(
    parameter  int NUM_THREADS = 16,
    localparam int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] launch_mask,
    input  logic                   issue_is_load,
    input  logic                   resp_valid,
    input  logic [TID_W-1:0]       resp_tid,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid,
    output logic [NUM_THREADS-1:0] ready_mask,
    output logic                   proto_err
);
    logic [NUM_THREADS-1:0] wait_mask;
    logic [TID_W-1:0]       last_q;

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_ctx
        thread_ctx u_ctx (
            .clk      (clk),
            .rst      (rst),
            .launch   (launch_mask[g]),
            .issue_me (issue_valid && (issue_tid == TID_W'(g))),
            .is_load  (issue_is_load),
            .resp_me  (resp_valid && (resp_tid == TID_W'(g))),
            .ready    (ready_mask[g]),
            .waiting  (wait_mask[g])
        );
    end

    rr_picker #(.N(NUM_THREADS), .ID_W(TID_W)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .req       (ready_mask),
        .last_id   (last_q),
        .gnt_valid (issue_valid),
        .gnt_id    (issue_tid)
    );

    // Reset value makes the first search begin at thread 0.
    always_ff @(posedge clk) begin
        if (rst)              last_q <= TID_W'(NUM_THREADS - 1);
        else if (issue_valid) last_q <= issue_tid;
    end

    assign proto_err = resp_valid && !wait_mask[resp_tid];

    AST_ISSUED_READY: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> ready_mask[issue_tid]); // R3
    AST_NO_BACK_TO_BACK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_is_load) |=> !(issue_valid && issue_tid == $past(issue_tid))); // R6
    AST_ERR_NOT_WAITING: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !wait_mask[resp_tid]); // R8
    AST_ERR_NEEDS_RESP: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> !proto_err); // R8
endmodule

// File: tb/sim_thread_issue_sched.sv
module sim_thread_issue_sched;
    localparam int N   = 128;
    localparam int TW  = $clog2(N);
    localparam int LAT = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  launch_mask = '0;
    logic          issue_is_load = 1'b0;
    logic          resp_valid = 1'b0;
    logic [TW-1:0] resp_tid = '0;
    logic          issue_valid;
    logic [TW-1:0] issue_tid;
    logic [N-1:0]  ready_mask;
    logic          proto_err;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    int due  [N];
    bit prog [N];

    thread_issue_sched #(.NUM_THREADS(N)) u0 (
        .clk(clk), .rst(rst), .launch_mask(launch_mask),
        .issue_is_load(issue_is_load), .resp_valid(resp_valid),
        .resp_tid(resp_tid), .issue_valid(issue_valid),
        .issue_tid(issue_tid), .ready_mask(ready_mask), .proto_err(proto_err)
    );

    always #5 clk = ~clk;

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: memory model drives due responses, decode answers issue_is_load.
    task automatic step();
        @(negedge clk);
        cyc++;
        resp_valid = 1'b0;
        resp_tid   = '0;
        for (int t = 0; t < N; t++) begin
            if (due[t] == cyc) begin
                resp_valid = 1'b1;
                resp_tid   = TW'(t);
                due[t]     = -1;
            end
        end
        issue_is_load = issue_valid ? prog[issue_tid] : 1'b0;
        if (issue_valid && prog[issue_tid]) due[issue_tid] = cyc + LAT;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; launch_mask = '0; resp_valid = 1'b0; issue_is_load = 1'b0;
        for (int t = 0; t < N; t++) due[t] = -1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic launch(logic [N-1:0] m);
        launch_mask = m;
        step();
        launch_mask = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [N-1:0] m;
        for (int t = 0; t < N; t++) begin due[t] = -1; prog[t] = 1'b0; end
        do_reset();
        // R1: reset state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(issue_valid == 1'b0, "R1", int'(issue_valid), 0);
        chk(ready_mask == '0, "R1", int'($countones(ready_mask)), 0);
        rst = 1'b0;

        // R3 bubble with no thread ready; R4/R5 round-robin over ALU threads
        do_reset();
        step();
        chk(issue_valid == 1'b0, "R3", int'(issue_valid), 0);
        m = '0; m[2] = 1'b1; m[5] = 1'b1; m[9] = 1'b1;
        launch(m);
        for (int r = 0; r < 6; r++) begin
            int e;
            e = (r % 3 == 0) ? 2 : (r % 3 == 1) ? 5 : 9;
            if (r > 0) step();
            chk(issue_valid && issue_tid == TW'(e), "R4", int'(issue_tid), e);
        end
        chk(ready_mask[2] && ready_mask[5] && ready_mask[9], "R5",
            int'($countones(ready_mask)), 3);

        // R5: lone ALU thread issues every cycle
        do_reset();
        m = '0; m[11] = 1'b1;
        launch(m);
        for (int r = 0; r < 4; r++) begin
            if (r > 0) step();
            chk(issue_valid && issue_tid == TW'(11), "R5", int'(issue_tid), 11);
        end

        // R6/R7 load latency; R2 launch of a waiting thread ignored
        do_reset();
        prog[4] = 1'b1;
        m = '0; m[4] = 1'b1;
        launch(m);
        chk(issue_valid && issue_tid == TW'(4), "R6", int'(issue_tid), 4);
        for (int r = 1; r <= LAT; r++) begin
            step();
            chk(issue_valid == 1'b0, "R6", int'(issue_valid), 0);
            if (r == 5) launch_mask = m;
            if (r == 6) begin
                launch_mask = '0;
                chk(ready_mask[4] == 1'b0, "R2", int'(ready_mask[4]), 0);
            end
        end
        step();
        chk(issue_valid && issue_tid == TW'(4), "R7", int'(issue_tid), 4);
        prog[4] = 1'b0;

        // R8: stray responses flagged and ignored
        do_reset();
        m = '0; m[3] = 1'b1;
        launch(m);
        chk(proto_err == 1'b0, "R8", int'(proto_err), 0);
        resp_valid = 1'b1; resp_tid = TW'(3);
        #1 chk(proto_err == 1'b1, "R8", int'(proto_err), 1);
        step();
        chk(issue_valid && issue_tid == TW'(3) && ready_mask[3], "R8", int'(issue_tid), 3);
        resp_valid = 1'b1; resp_tid = TW'(7);
        #1 chk(proto_err == 1'b1, "R8", int'(proto_err), 1);
        step();
        chk(ready_mask[7] == 1'b0, "R8", int'(ready_mask[7]), 0);
        chk(issue_valid && issue_tid == TW'(3), "R8", int'(issue_tid), 3);

        // R9: enough threads to cover latency, every slot filled
        do_reset();
        for (int t = 0; t < N; t++) prog[t] = 1'b1;
        launch('1);
        for (int r = 0; r < 3 * N; r++) begin
            if (r > 0) step();
            chk(issue_valid && issue_tid == TW'(r % N), "R9", int'(issue_tid), r % N);
        end

        // R10: 40 active threads, 40 issues per LAT+1 window
        do_reset();
        m = '0;
        for (int t = 0; t < 40; t++) m[t] = 1'b1;
        launch(m);
        for (int r = 0; r < 3 * (LAT + 1); r++) begin
            int ph;
            ph = r % (LAT + 1);
            if (r > 0) step();
            if (ph < 40)
                chk(issue_valid && issue_tid == TW'(ph), "R10", int'(issue_tid), ph);
            else
                chk(issue_valid == 1'b0, "R10", int'(issue_valid), 0);
        end

        finish_run();
    end
endmodule